// File: doc/BRIEF.md
# Interval Measurement Controller

This block measures the time between a start event and a stop event and reports it in half-periods of its clock. A 2-bit command, qualified by a valid strobe, arms it in one of two ways. In the free-running mode counting may begin as soon as the start input is active. In the edge-synchronized mode the start input must first be seen inactive and then become active again. This guarantees that the interval begins on a real start edge, which matters for frequency measurement. The start and stop inputs are already selected and synchronized level signals, and each has a polarity bit.

The result register gains two per clock, so it counts both edges of the clock. Counting ends on a stop event, on saturation, or on an abort. The saturation point is a selectable bit of the result. An optional skip counter lets the block pass over a programmed number of stop edges, so that one measurement can cover several periods of a signal. A done flag, a saturation flag and a 6-bit state code show progress. The live skip counter is brought out as well.

Top module: `tdc_engine`

## Requirements
- R1: While reset is high the state code is 0x0F, and the result, done and sat are all 0. One clock after reset is released the state code is 0x06 (idle).
- R2: Command codes: 0 clears the result, 1 runs with a synchronized start, 2 runs freely, 3 aborts. An abort given in any state except idle and 0x0F moves to state 0x2E for one cycle and then to idle. The result is kept and done stays 0. Run commands given outside idle are ignored.
- R3: A run command in idle steps through states 0x07 and 0x16. In free-running mode it then reaches wait-for-start (0x00), and counting begins on the first clock where start is active, even if start was already active before the command.
- R4: In synchronized mode the block waits in state 0x1E until start is seen inactive, then moves to 0x00. It begins counting only when start becomes active again.
- R5: While counting (state 0x08, or 0x0C when the skip counter is enabled) the result grows by 2 per clock. If start is applied k clocks before the stopping event, the result is 2*(k-1).
- R6: When the measurement ends, the block spends one cycle in state 0x0E with done set, then returns to idle. Done holds its value until it is cleared.
- R7: The 4-bit saturation code c selects result bit c+9 (15 gives bit 24, 3 gives bit 12). Codes below 3 act as 3. When that bit becomes set, counting stops with the result equal to 2^(c+9), and sat and done are set.
- R8: With the skip counter enabled, stop events are edges where stop goes from inactive to active. The measurement ends on edge N, where N is the loaded count, and load values 0 and 1 both end it on the first edge. With the skip counter disabled, the first active stop level ends it.
- R9: Entering state 0x07 copies the load value into the skip counter. A skip write while idle sets the live count directly. A skip write in any other state leaves the count unchanged.
- R10: The clear command in idle sets the result, done and sat to 0. In other states the clear command has no effect. Starting a new measurement also clears all three.
- R11: A polarity bit of 0 makes the input active when high, and a bit of 1 makes it active when low. This applies to start and to stop independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge stands for two counted edges |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd | input | 2 | Command code (0 clear, 1 sync run, 2 run, 3 abort) |
| start_in | input | 1 | Start event level |
| stop_in | input | 1 | Stop event level |
| start_act_low | input | 1 | Start polarity: 1 means active when low |
| stop_act_low | input | 1 | Stop polarity: 1 means active when low |
| sat_code | input | 4 | Saturation bit select |
| skip_en | input | 1 | Enable the stop skip counter |
| skip_load | input | 16 | Value loaded into the skip counter at each start |
| skip_wr | input | 1 | Write strobe for the live skip counter |
| skip_wdata | input | 16 | Data for a live skip counter write |
| result | output | 25 | Measured interval in clock half-periods |
| done | output | 1 | Measurement complete flag |
| sat | output | 1 | Measurement stopped by saturation |
| state_code | output | 6 | Encoded controller state |
| skip_count | output | 16 | Live skip counter value |

## Verification
On every cycle, the assertions check the state steps: abort leads to force-stop, result-ready lasts one cycle with done high, and reset leaves state 0x0F for idle. They also check that the result only holds its value or grows by exactly two, that saturation ends a measurement, and that skip writes outside idle do not change the count. Some things only the bench's scenarios can show: the interval values for given start and stop timing, the difference between synchronized and free-running starts when start is already active, stop edges counted across multiple pulses, the two polarities, and the exact result at each saturation code.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    localparam int RES_W   = 25;
    localparam int SKIP_W  = 16;
    localparam int SEL_W   = 4;
    localparam int STATE_W = 6;

    typedef enum logic [1:0] {
        CMD_CLEAR    = 2'd0,
        CMD_RUN_SYNC = 2'd1,
        CMD_RUN      = 2'd2,
        CMD_ABORT    = 2'd3
    } cmd_e;

    typedef enum logic [STATE_W-1:0] {
        ST_WAIT_START  = 6'h00,
        ST_IDLE        = 6'h06,
        ST_CLR_CNT     = 6'h07,
        ST_WAIT_STOP   = 6'h08,
        ST_WAIT_STOPCD = 6'h0C,
        ST_GET_RESULT  = 6'h0E,
        ST_POR         = 6'h0F,
        ST_CLR_WAIT    = 6'h16,
        ST_START_FALL  = 6'h1E,
        ST_FORCE_STOP  = 6'h2E
    } state_e;

    // Control strobes produced by the sequencer for the datapath
    typedef struct packed {
        logic clr;       // zero the result
        logic inc;       // add two to the result
        logic load;      // reload the skip counter
        logic dec;       // consume one stop edge
        logic set_done;
        logic set_sat;
        logic clr_flags;
    } ctl_t;

    // Conditioned trigger view
    typedef struct packed {
        logic start_act;
        logic start_rise;
        logic stop_act;
        logic stop_rise;
    } trig_t;

    // Saturation bit index: code 15 maps to the top bit of a 25-bit result
    function automatic int sat_index(input logic [SEL_W-1:0] code, input int res_w);
        int c;
        c = (code < 4'd3) ? 3 : int'(code);
        return res_w - 16 + c;
    endfunction

endpackage

// File: rtl/tdc_trig.sv
module tdc_trig #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] lvl,
    input  logic [NCH-1:0] act_low,
    output logic [NCH-1:0] act,
    output logic [NCH-1:0] rise
);
    logic [NCH-1:0] act_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign act[i]  = lvl[i] ^ act_low[i];
        assign rise[i] = act[i] & ~act_q[i];

        always_ff @(posedge clk) begin
            if (rst) act_q[i] <= 1'b0;
            else     act_q[i] <= act[i];
        end
    end
endmodule

// File: rtl/tdc_accum.sv
module tdc_accum
    import tdc_pkg::*;
#(
    parameter int RW = tdc_pkg::RES_W,
    parameter int SW = tdc_pkg::SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    input  logic [SW-1:0] sat_code,
    output logic [RW-1:0] result,
    output logic          sat_hit
);
    localparam int IDX_W = $clog2(RW);

    logic [RW-1:0]    res_q;
    logic [IDX_W-1:0] idx;

    assign idx     = IDX_W'(sat_index(sat_code, RW));
    assign sat_hit = res_q[idx];
    assign result  = res_q;

    always_ff @(posedge clk) begin
        if (rst)      res_q <= '0;
        else if (clr) res_q <= '0;
        else if (inc) res_q <= res_q + RW'(2);
    end

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr && !inc) |=> $stable(res_q)); // R5
    AST_RESULT_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> (res_q == $past(res_q) + RW'(2))); // R5
endmodule

// File: rtl/tdc_skipcnt.sv
module tdc_skipcnt #(
    parameter int CW = tdc_pkg::SKIP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    input  logic          idle,
    input  logic          wr,
    input  logic [CW-1:0] wr_val,
    output logic [CW-1:0] cnt,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    assign cnt  = cnt_q;
    assign last = (cnt_q <= CW'(1));

    always_ff @(posedge clk) begin
        if (rst)                  cnt_q <= '0;
        else if (load)            cnt_q <= load_val;
        else if (dec)             cnt_q <= cnt_q - CW'(1);
        else if (wr && idle)      cnt_q <= wr_val;
    end

    AST_SKIP_WR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr && !idle && !load && !dec) |=> $stable(cnt_q)); // R9
    AST_SKIP_RELOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val))); // R9
endmodule

// File: rtl/tdc_fsm.sv
module tdc_fsm
    import tdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [1:0] cmd,
    input  trig_t      trig,
    input  logic       skip_en,
    input  logic       sat_hit,
    input  logic       skip_last,
    output state_e     state,
    output ctl_t       ctl,
    output logic       done,
    output logic       sat
);
    state_e st_q, st_d;
    logic   sync_q, sync_d;
    logic   done_q, sat_q;
    logic   abort_req;
    logic   active;

    assign active    = (st_q != ST_IDLE) && (st_q != ST_POR);
    assign abort_req = cmd_valid && (cmd_e'(cmd) == CMD_ABORT) && active;

    always_comb begin
        st_d   = st_q;
        sync_d = sync_q;
        ctl    = '0;
        unique case (st_q)
            ST_POR: st_d = ST_IDLE;
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (cmd_e'(cmd))
                        CMD_CLEAR: begin
                            ctl.clr       = 1'b1;
                            ctl.clr_flags = 1'b1;
                        end
                        CMD_RUN_SYNC: begin
                            st_d   = ST_CLR_CNT;
                            sync_d = 1'b1;
                        end
                        CMD_RUN: begin
                            st_d   = ST_CLR_CNT;
                            sync_d = 1'b0;
                        end
                        default: ;
                    endcase
                end
            end
            ST_CLR_CNT: begin
                ctl.clr       = 1'b1;
                ctl.load      = 1'b1;
                ctl.clr_flags = 1'b1;
                st_d          = ST_CLR_WAIT;
            end
            ST_CLR_WAIT: st_d = sync_q ? ST_START_FALL : ST_WAIT_START;
            ST_START_FALL: begin
                if (!trig.start_act) st_d = ST_WAIT_START;
            end
            ST_WAIT_START: begin
                if (sync_q ? trig.start_rise : trig.start_act)
                    st_d = skip_en ? ST_WAIT_STOPCD : ST_WAIT_STOP;
            end
            ST_WAIT_STOP: begin
                if (sat_hit) begin
                    ctl.set_sat  = 1'b1;
                    ctl.set_done = 1'b1;
                    st_d         = ST_GET_RESULT;
                end else if (trig.stop_act) begin
                    ctl.set_done = 1'b1;
                    st_d         = ST_GET_RESULT;
                end else begin
                    ctl.inc = 1'b1;
                end
            end
            ST_WAIT_STOPCD: begin
                if (sat_hit) begin
                    ctl.set_sat  = 1'b1;
                    ctl.set_done = 1'b1;
                    st_d         = ST_GET_RESULT;
                end else if (trig.stop_rise && skip_last) begin
                    ctl.set_done = 1'b1;
                    st_d         = ST_GET_RESULT;
                end else begin
                    ctl.inc = 1'b1;
                    ctl.dec = trig.stop_rise;
                end
            end
            ST_GET_RESULT: st_d = ST_IDLE;
            ST_FORCE_STOP: st_d = ST_IDLE;
            default:       st_d = ST_IDLE;
        endcase
        if (abort_req) begin
            st_d = ST_FORCE_STOP;
            ctl  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_POR;
            sync_q <= 1'b0;
            done_q <= 1'b0;
            sat_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            sync_q <= sync_d;
            if (ctl.clr_flags) begin
                done_q <= 1'b0;
                sat_q  <= 1'b0;
            end else begin
                if (ctl.set_done) done_q <= 1'b1;
                if (ctl.set_sat)  sat_q  <= 1'b1;
            end
        end
    end

    assign state = st_q;
    assign done  = done_q;
    assign sat   = sat_q;

    AST_ABORT_FORCES: assert property (@(posedge clk) disable iff (rst)
        abort_req |=> (st_q == ST_FORCE_STOP)); // R2
    AST_DONE_IN_GET: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_GET_RESULT) |-> done_q); // R6
    AST_GET_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_GET_RESULT) |=> (st_q == ST_IDLE)); // R6
    AST_SAT_ENDS: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_WAIT_STOP || st_q == ST_WAIT_STOPCD) && sat_hit && !abort_req)
        |=> (st_q == ST_GET_RESULT && sat_q)); // R7
    AST_POR_EXIT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_POR) |=> (st_q == ST_IDLE)); // R1
endmodule

// File: rtl/tdc_engine.sv
module tdc_engine
    import tdc_pkg::*;
#(
    parameter int RW = tdc_pkg::RES_W,
    parameter int CW = tdc_pkg::SKIP_W,
    parameter int SW = tdc_pkg::SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd,
    input  logic          start_in,
    input  logic          stop_in,
    input  logic          start_act_low,
    input  logic          stop_act_low,
    input  logic [SW-1:0] sat_code,
    input  logic          skip_en,
    input  logic [CW-1:0] skip_load,
    input  logic          skip_wr,
    input  logic [CW-1:0] skip_wdata,
    output logic [RW-1:0] result,
    output logic          done,
    output logic          sat,
    output logic [5:0]    state_code,
    output logic [CW-1:0] skip_count
);
    logic [1:0] act, rise;
    trig_t      trig;
    ctl_t       ctl;
    state_e     state;
    logic       sat_hit, skip_last;

    tdc_trig #(.NCH(2)) u_trig (
        .clk     (clk),
        .rst     (rst),
        .lvl     ({stop_in, start_in}),
        .act_low ({stop_act_low, start_act_low}),
        .act     (act),
        .rise    (rise)
    );

    assign trig = '{start_act: act[0], start_rise: rise[0],
                    stop_act: act[1], stop_rise: rise[1]};

    tdc_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .trig      (trig),
        .skip_en   (skip_en),
        .sat_hit   (sat_hit),
        .skip_last (skip_last),
        .state     (state),
        .ctl       (ctl),
        .done      (done),
        .sat       (sat)
    );

    tdc_accum #(.RW(RW), .SW(SW)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .clr      (ctl.clr),
        .inc      (ctl.inc),
        .sat_code (sat_code),
        .result   (result),
        .sat_hit  (sat_hit)
    );

    tdc_skipcnt #(.CW(CW)) u_skip (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.load),
        .load_val (skip_load),
        .dec      (ctl.dec),
        .idle     (state == ST_IDLE),
        .wr       (skip_wr),
        .wr_val   (skip_wdata),
        .cnt      (skip_count),
        .last     (skip_last)
    );

    assign state_code = state;

    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !cmd_valid) |=> $stable(result)); // R10
endmodule

// File: tb/tdc_engine_bench.sv
module tdc_engine_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd;
    logic        start_in, stop_in, start_act_low, stop_act_low;
    logic [3:0]  sat_code;
    logic        skip_en, skip_wr;
    logic [15:0] skip_load, skip_wdata;
    logic [24:0] result;
    logic        done, sat;
    logic [5:0]  state_code;
    logic [15:0] skip_count;

    int checks = 0;
    int bad    = 0;

    always #2 clk = ~clk;

    tdc_engine u_tdc_engine (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd),
        .start_in(start_in), .stop_in(stop_in),
        .start_act_low(start_act_low), .stop_act_low(stop_act_low),
        .sat_code(sat_code), .skip_en(skip_en), .skip_load(skip_load),
        .skip_wr(skip_wr), .skip_wdata(skip_wdata),
        .result(result), .done(done), .sat(sat),
        .state_code(state_code), .skip_count(skip_count)
    );

    function automatic int exp_interval(input int k);
        return 2 * (k - 1);
    endfunction

    function automatic int exp_sat(input int code);
        int c;
        c = (code < 3) ? 3 : code;
        return 1 << (c + 9);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] c);
        cmd_valid = 1'b1; cmd = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // One full measurement; k counts clocks from start drive to final stop drive
    task automatic measure(input bit sync, input bit sk_en, input int load,
                           input bit slo, input bit plo, input int kf,
                           input int npulse, input int pgap, input string req);
        int k;
        start_act_low = slo; stop_act_low = plo;
        start_in = slo; stop_in = plo;
        skip_en = sk_en; skip_load = 16'(load);
        @(negedge clk);
        issue(sync ? 2'd1 : 2'd2);
        repeat (4) @(negedge clk);
        start_in = ~slo;
        repeat (kf) @(negedge clk);
        k = kf;
        stop_in = ~plo;
        for (int p = 1; p < npulse; p++) begin
            @(negedge clk);
            stop_in = plo;
            repeat (pgap) @(negedge clk);
            stop_in = ~plo;
            k += 1 + pgap;
        end
        repeat (3) @(negedge clk);
        start_in = slo; stop_in = plo;
        chk(result == 25'(exp_interval(k)), req, int'(result), exp_interval(k));
        chk(done == 1'b1 && sat == 1'b0, req, {done, sat}, 2);
        chk(state_code == 6'h06, req, state_code, 6'h06);
    endtask

    task automatic sat_run(input int code, input string req);
        sat_code = 4'(code);
        start_act_low = 0; stop_act_low = 0; start_in = 0; stop_in = 0;
        skip_en = 0;
        issue(2'd2);
        repeat (3) @(negedge clk);
        chk(done == 0 && sat == 0, "R10 flags cleared at start", {done, sat}, 0);
        start_in = 1;
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
        @(negedge clk);
        chk(result == 25'(exp_sat(code)), req, int'(result), exp_sat(code));
        chk(sat == 1 && done == 1, req, {sat, done}, 3);
        start_in = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++; checks++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1; cmd_valid = 0; cmd = 0; start_in = 0; stop_in = 0;
        start_act_low = 0; stop_act_low = 0; sat_code = 4'd15;
        skip_en = 0; skip_wr = 0; skip_load = 0; skip_wdata = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(state_code == 6'h0F, "R1 reset state", state_code, 6'h0F);
        chk(result == 0 && done == 0 && sat == 0, "R1 reset outputs", result, 0);
        rst = 0;
        @(negedge clk);
        chk(state_code == 6'h06, "R1 idle after reset", state_code, 6'h06);

        // R9 live write in idle
        skip_wr = 1; skip_wdata = 16'd7; @(negedge clk); skip_wr = 0;
        chk(skip_count == 16'd7, "R9 idle write", skip_count, 7);

        // R3 state walk for a free run
        issue(2'd2);
        chk(state_code == 6'h07, "R3 clear-count state", state_code, 6'h07);
        @(negedge clk);
        chk(state_code == 6'h16, "R3 clear-wait state", state_code, 6'h16);
        @(negedge clk);
        chk(state_code == 6'h00, "R3 wait-start state", state_code, 6'h00);
        // R2 run command ignored outside idle, R10 clear ignored
        issue(2'd1);
        chk(state_code == 6'h00, "R2 run ignored when busy", state_code, 6'h00);
        issue(2'd0);
        chk(state_code == 6'h00, "R10 clear ignored when busy", state_code, 6'h00);
        // R9 write outside idle ignored (counter loaded with 0)
        skip_wr = 1; skip_wdata = 16'd99; @(negedge clk); skip_wr = 0;
        chk(skip_count == 16'd0, "R9 busy write ignored", skip_count, 0);
        issue(2'd3);
        chk(state_code == 6'h2E, "R2 force stop", state_code, 6'h2E);
        @(negedge clk);
        chk(state_code == 6'h06, "R2 back to idle", state_code, 6'h06);

        // R3 free run with start already active begins at once
        start_in = 1;
        issue(2'd2);
        repeat (3) @(negedge clk);
        chk(state_code == 6'h08, "R3 immediate start", state_code, 6'h08);
        repeat (5) @(negedge clk);
        issue(2'd3);
        @(negedge clk);
        chk(done == 0 && result != 0, "R2 abort keeps result", result, 1);
        start_in = 0;

        // R4 synchronized start waits for a fall
        start_in = 1;
        issue(2'd1);
        repeat (8) @(negedge clk);
        chk(state_code == 6'h1E && result == 0, "R4 wait for fall", state_code, 6'h1E);
        start_in = 0;
        repeat (2) @(negedge clk);
        chk(state_code == 6'h00, "R4 fall seen", state_code, 6'h00);
        issue(2'd3);
        @(negedge clk);

        // R5 directed intervals, R11 polarities
        measure(0, 0, 0, 0, 0, 5, 1, 1, "R5 plain interval");
        measure(1, 0, 0, 1, 1, 9, 1, 1, "R11 active-low sync interval");
        // R6 done holds in idle
        repeat (4) @(negedge clk);
        chk(done == 1, "R6 done held", done, 1);
        // R10 clear in idle
        issue(2'd0);
        chk(result == 0 && done == 0 && sat == 0, "R10 clear in idle", result, 0);

        // R8 skip counting
        measure(0, 1, 3, 0, 0, 4, 3, 2, "R8 third stop edge");
        measure(0, 1, 0, 0, 1, 6, 1, 1, "R8 load zero");
        measure(1, 1, 1, 1, 0, 3, 1, 1, "R8 load one");
        measure(0, 1, 5, 0, 0, 2, 5, 1, "R8 fifth stop edge");

        // R7 saturation
        sat_run(3, "R7 bit 12");
        sat_run(0, "R7 low code acts as 3");
        sat_run(5, "R7 bit 14");
        sat_code = 4'd15;

        // R5 random mix
        for (int it = 0; it < 16; it++) begin
            bit sy, ke, sl, pl;
            int ld, np, kf, pg;
            sy = 1'($urandom % 2); ke = 1'($urandom % 2);
            sl = 1'($urandom % 2); pl = 1'($urandom % 2);
            ld = $urandom % 5;
            np = (ke && ld > 1) ? ld : 1;
            kf = 2 + $urandom % 20;
            pg = 1 + $urandom % 3;
            measure(sy, ke, ld, sl, pl, kf, np, pg, "R5 random interval");
        end

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule